// File: doc/BRIEF.md
# Shared Random Word Source with Per-Core Views

This block holds one 32-bit linear feedback shift register and hands a random word to each of several processor cores. The register takes a fixed nonzero seed under reset and then steps once on every clock, whether or not anything reads it. No core has a generator of its own. Each core sees the shared state through two fixed transformations: first a bit reordering chosen for that core, then an XOR with a constant chosen for that core. Because the transformations differ, cores that read in the same cycle get different words from one underlying sequence.

A core raises its read-enable for one cycle. On the next cycle its output port shows the word taken from the state that was present at that edge. The output then holds until that core reads again. Any number of cores may read in the same cycle. Software writes nothing to the block before it uses it.

Top module: `shared_rng_views`

## Requirements
- R1: There is one shared 32-bit state register. While `rst` is high at a rising edge it loads `SEED` (default 32'h1F2E_3D4C). The first read after reset release returns the view of `SEED`.
- R2: On every rising edge with `rst` low the state moves from s to {s[30:0], s[31]^s[21]^s[1]^s[0]} (taps 32, 22, 2, 1). The state never becomes zero, and it changes on every edge.
- R3: The view of core i first rotates the state left by (4*i) mod 32 bit places, so that bit b moves to bit (b+4i) mod 32. For odd i the result is then bit-reversed, so that bit b moves to bit 31-b.
- R4: The permuted word of core i is XORed with the mask MASK_BASE ^ (i*MASK_STEP) mod 2^32. The defaults are 32'h5A3C_96E1 and 32'h9E37_79B9. MASK_STEP is odd, so every core's mask is distinct.
- R5: When `rd_en_i[i]` is high at a rising edge, `rnd_o[32*i +: 32]` shows, after that edge, the view of the state held just before that edge.
- R6: When `rd_en_i[i]` is low at a rising edge, that core's output keeps its previous value.
- R7: Several cores reading at the same edge are all served from the same state value, each through its own view.
- R8: While `rst` is high, every core output is cleared to zero after the edge.
- R9: Cores that read at the same edge receive different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | NUM_CORES | Read request for each core, bit i belongs to core i |
| rnd_o | output | 32*NUM_CORES | Registered random word for each core, core i in bits 32*i+31 down to 32*i |

## Verification
The two functions that can fall in the same cycle are the state step and the capture of words by several cores. Each capturing core must use the state from before the step, and every core must use the same value. The bench provokes this by raising all enables at once, then alternating patterns, then walking a single enable. Between these it places idle stretches and a reset in mid-run. A software model of the register predicts each core's word. Each captured word is judged against that prediction, and the words of the cores that read together are compared pairwise to show that they differ.

// File: rtl/shared_rng_pkg.sv
package shared_rng_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        VIEW_PLAIN    = 1'b0,
        VIEW_REVERSED = 1'b1
    } view_kind_e;

    typedef struct packed {
        logic  take;
        word_t value;
    } capture_t;

    localparam word_t DEF_SEED      = 32'h1F2E_3D4C;
    localparam word_t DEF_MASK_BASE = 32'h5A3C_96E1;
    localparam word_t DEF_MASK_STEP = 32'h9E37_79B9;

    function automatic word_t lfsr_step(input word_t s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[WORD_W-2:0], fb};
    endfunction

    function automatic word_t rotate_left(input word_t s, input int amt);
        word_t r;
        for (int b = 0; b < WORD_W; b++) begin
            r[(b + amt) % WORD_W] = s[b];
        end
        return r;
    endfunction

    function automatic word_t reverse_bits(input word_t s);
        word_t r;
        for (int b = 0; b < WORD_W; b++) begin
            r[WORD_W-1-b] = s[b];
        end
        return r;
    endfunction

    function automatic word_t core_mask(input int idx, input word_t base, input word_t step);
        word_t prod;
        prod = word_t'(idx) * step;
        return base ^ prod;
    endfunction

endpackage

// File: rtl/srv_lfsr.sv
module srv_lfsr
    import shared_rng_pkg::*;
#(
    parameter word_t SEED = DEF_SEED
) (
    input  logic  clk,
    input  logic  rst,
    output word_t state_o
);

    word_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign state_o = state_q;

    // R1: the cycle after a reset edge shows the seed
    a_r1_seed_load: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_q == SEED);

    // R2: the all-zero lock-up state is never reached
    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R2: the state moves on every edge out of reset
    a_r2_moves: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> state_q != $past(state_q));

endmodule

// File: rtl/srv_core_tap.sv
module srv_core_tap
    import shared_rng_pkg::*;
#(
    parameter int    IDX       = 0,
    parameter word_t MASK_BASE = DEF_MASK_BASE,
    parameter word_t MASK_STEP = DEF_MASK_STEP
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t state_i,
    input  logic  rd_en_i,
    output word_t word_o
);

    localparam int         ROT_AMT = (4 * IDX) % WORD_W;
    localparam view_kind_e KIND    = (IDX % 2 == 1) ? VIEW_REVERSED : VIEW_PLAIN;
    localparam word_t      MASK    = core_mask(IDX, MASK_BASE, MASK_STEP);

    word_t    rotated;
    word_t    permuted;
    capture_t cap;
    word_t    word_q;

    assign rotated = rotate_left(state_i, ROT_AMT);

    generate
        if (KIND == VIEW_REVERSED) begin : g_rev
            assign permuted = reverse_bits(rotated);
        end else begin : g_plain
            assign permuted = rotated;
        end
    endgenerate

    always_comb begin
        cap.take  = rd_en_i;
        cap.value = permuted ^ MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (cap.take) begin
            word_q <= cap.value;
        end
    end

    assign word_o = word_q;

    // R6: an idle core keeps its word
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(word_o));

    // R8: reset clears the core output
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> word_o == '0);

endmodule

// File: rtl/shared_rng_views.sv
module shared_rng_views
    import shared_rng_pkg::*;
#(
    parameter int    NUM_CORES = 8,
    parameter word_t SEED      = DEF_SEED,
    parameter word_t MASK_BASE = DEF_MASK_BASE,
    parameter word_t MASK_STEP = DEF_MASK_STEP
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CORES-1:0]        rd_en_i,
    output logic [NUM_CORES*WORD_W-1:0] rnd_o
);

    word_t shared_state;

    srv_lfsr #(.SEED(SEED)) lfsr_i (
        .clk     (clk),
        .rst     (rst),
        .state_o (shared_state)
    );

    generate
        for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
            word_t tap_word;

            srv_core_tap #(
                .IDX       (i),
                .MASK_BASE (MASK_BASE),
                .MASK_STEP (MASK_STEP)
            ) tap_i (
                .clk     (clk),
                .rst     (rst),
                .state_i (shared_state),
                .rd_en_i (rd_en_i[i]),
                .word_o  (tap_word)
            );

            assign rnd_o[i*WORD_W +: WORD_W] = tap_word;
        end
    endgenerate

    // R1: the shared state is never held at zero while outputs are served
    a_r1_state_live: assert property (@(posedge clk) disable iff (rst)
        (|rd_en_i) |-> shared_state != '0);

endmodule

// File: tb/shared_rng_views_tb_top.sv
module shared_rng_views_tb_top;

    localparam int          NC    = 8;
    localparam logic [31:0] SEED  = 32'h1F2E_3D4C;
    localparam logic [31:0] MBASE = 32'h5A3C_96E1;
    localparam logic [31:0] MSTEP = 32'h9E37_79B9;

    typedef struct {
        int          core;
        logic [31:0] val;
        string       tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   rd_en = '0;
    logic [NC*32-1:0] rnd;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit done = 0;

    item_t       sb_q[$];
    logic [31:0] model;
    logic [31:0] exp_word [NC];
    bit          read_last [NC];
    bit          rst_last;

    shared_rng_views #(.NUM_CORES(NC)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en_i (rd_en),
        .rnd_o   (rnd)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] m_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [31:0] m_view(input logic [31:0] s, input int i);
        logic [31:0] r;
        logic [31:0] o;
        int k;
        k = (4 * i) % 32;
        for (int b = 0; b < 32; b++) r[(b + k) % 32] = s[b];
        if (i % 2 == 1) begin
            for (int b = 0; b < 32; b++) o[31 - b] = r[b];
        end else begin
            o = r;
        end
        return o ^ (MBASE ^ (32'(i) * MSTEP));
    endfunction

    function automatic logic [31:0] core_out(input int i);
        return rnd[i*32 +: 32];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input int core);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s core %0d: actual %h expected %h", tag, core, act, exp);
        end
    endtask

    // driver side of the scoreboard: predicts at each edge
    always @(posedge clk) begin
        int nread;
        started = 1;
        rst_last = rst;
        nread = 0;
        for (int i = 0; i < NC; i++) nread += rd_en[i] ? 1 : 0;
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                exp_word[i] = '0;
                read_last[i] = 0;
            end
            model = SEED;
        end else begin
            for (int i = 0; i < NC; i++) begin
                read_last[i] = rd_en[i];
                if (rd_en[i]) begin
                    item_t it;
                    it.core = i;
                    it.val  = m_view(model, i);
                    // R1 seed view, R7 shared capture, R5 single capture; R2 R3 R4 in value
                    it.tag  = (model == SEED) ? "R1 R3 R4" : (nread > 1) ? "R7 R2 R3 R4" : "R5 R2 R3 R4";
                    exp_word[i] = it.val;
                    sb_q.push_back(it);
                end
            end
            model = m_next(model);
        end
    end

    // monitor side: compares away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, core_out(it.core), it.val, it.core);
            end
            for (int i = 0; i < NC; i++) begin
                if (rst_last) check("R8", core_out(i), 32'h0, i);
                else if (!read_last[i]) check("R6", core_out(i), exp_word[i], i);
            end
            if (!rst_last) begin
                for (int a = 0; a < NC; a++) begin
                    for (int b = a + 1; b < NC; b++) begin
                        if (read_last[a] && read_last[b]) begin
                            compared++;
                            if (core_out(a) === core_out(b)) begin
                                mismatched++;
                                $display("FAIL R9 cores %0d/%0d: actual %h expected different from %h",
                                         a, b, core_out(a), core_out(b));
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic run(input logic [NC-1:0] pat, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rd_en = pat;
        end
    endtask

    initial begin
        rst = 1'b1;
        rd_en = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rd_en = '1;                       // first read sees the seed (R1)
        run('1, 40);                      // all cores together (R7, R9)
        for (int k = 0; k < NC; k++) run(NC'(1) << k, 2);  // one core at a time (R5)
        run('0, 10);                      // idle hold (R6)
        for (int k = 0; k < 10; k++) begin
            run({(NC/2){2'b01}}, 1);
            run({(NC/2){2'b10}}, 1);
        end
        run(8'b1000_0001, 5);
        @(negedge clk);
        rst = 1'b1;                       // mid-run reset (R8, R1)
        rd_en = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run('1, 6);
        run('0, 4);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule